// File: doc/BRIEF.md
# Saturating Misc-Op Execution Unit

This unit executes one opcode group of a 32-bit RISC core that uses a three-register instruction layout. The inputs are a 4-bit operation selector, the 4-bit destination and control fields of the instruction, and the values of the two source registers and of the current destination register. One clock later the unit returns a write-back value, a write enable for the destination register, and a flag that marks the operation as illegal.

The group contains several kinds of operation. Sign extension takes its extension point from the 4-bit control field plus seven. A signed saturating clamp uses the same bit position. There are signed and unsigned minimum and maximum operations. Four conditional moves copy the first source into the destination after testing the second source register against zero. Sign extension, clamp and min/max exist only when the misc-operation option is built in. The conditional moves are always present. Two selector codes are kept for moves on a boolean register file, and they raise the illegal flag when that option is absent. The special-register and user-register accesses that share this group are executed elsewhere, so here they are quiet no-ops.

Top module: `misc_exec_unit`

## Requirements
- R1: After synchronous reset, `out_valid`, `wb_en` and `illegal` are all 0, and they stay 0 until a valid strobe is accepted.
- R2: Each cycle with `in_valid`=1 gives exactly one cycle of `out_valid`=1 on the next clock edge. A cycle without `in_valid` gives `out_valid`=0. `wb_idx` returns the captured destination field.
- R3: Selector 2 (sign extend): with p = t_fld+7, the result keeps bits p..0 of s and fills bits 31..p+1 with bit p of s. The result is written.
- R4: Selector 3 (clamp): with p = t_fld+7, s passes unchanged when bits 31..p all equal bit 31 of s. Otherwise the result is -(2^p) for a negative s and 2^p-1 for a non-negative s. The result is written.
- R5: Selectors 4, 5, 6 and 7 are signed min, signed max, unsigned min and unsigned max. The result is s when s<=t (for min) or s>=t (for max) holds under the chosen signedness, and t otherwise. The result is written.
- R6: Selectors 8, 9, 10 and 11 write s when register t is zero, is non-zero, has bit 31 set, or has bit 31 clear, in that order. When the test fails, `wb_en` is 0.
- R7: Whenever `out_valid`=1 and `wb_en`=0, `wb_data` carries the captured current value of register r.
- R8: With the misc option disabled (HAS_MISC=0), selectors 2 to 7 set `illegal`=1 and `wb_en`=0.
- R9: Selectors 12 and 13 never write. They set `illegal`=1 when HAS_BOOL=0 and leave it 0 when HAS_BOOL=1.
- R10: Selectors 0, 1, 14 and 15 give `wb_en`=0 and `illegal`=0.
- R11: `illegal`=1 always comes with `wb_en`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| op_sel | input | 4 | Operation selector within the group |
| r_fld | input | 4 | Destination register field |
| t_fld | input | 4 | Control field; sets bit position t_fld+7 |
| s_val | input | 32 | Value of source register s |
| t_val | input | 32 | Value of source register t |
| r_val | input | 32 | Current value of destination register r |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| wb_en | output | 1 | Write enable for register r |
| wb_idx | output | 4 | Captured destination field |
| wb_data | output | 32 | Write-back value |
| illegal | output | 1 | Illegal-instruction report |

## Verification
In a single result cycle, the illegal report and the write path both act on one operation. A disabled misc op, or a boolean move, must raise the flag and also block the write that the datapath would otherwise make. The bench drives identical stimulus into two instances, one with the misc option and one without, sweeping every selector, every control-field value and a set of edge-case operands. For each result it checks the flag, the enable and the data together against an arithmetic model. Conditional moves whose test fails are judged in the same comparison, where the data must fall back to the old destination value.

// File: rtl/mx_pkg.sv
package mx_pkg;
  localparam int SEL_W = 4;

  typedef enum logic [SEL_W-1:0] {
    OP_SPR_RD  = 4'd0,
    OP_SPR_WR  = 4'd1,
    OP_SEXT    = 4'd2,
    OP_CLAMP   = 4'd3,
    OP_MIN     = 4'd4,
    OP_MAX     = 4'd5,
    OP_MINU    = 4'd6,
    OP_MAXU    = 4'd7,
    OP_MV_EQZ  = 4'd8,
    OP_MV_NEZ  = 4'd9,
    OP_MV_LTZ  = 4'd10,
    OP_MV_GEZ  = 4'd11,
    OP_BMV_F   = 4'd12,
    OP_BMV_T   = 4'd13,
    OP_UR_RD   = 4'd14,
    OP_UR_WR   = 4'd15
  } op_e;

  typedef struct packed {
    logic        ill;
    logic        wr;
  } ctl_t;
endpackage

// File: rtl/mx_bitpos.sv
module mx_bitpos #(
  parameter int XLEN    = 32,
  parameter int FIELD_W = 4,
  parameter int BASE    = 7
) (
  input  logic [XLEN-1:0]    s_val,
  input  logic [FIELD_W-1:0] t_fld,
  output logic [XLEN-1:0]    sext_res,
  output logic [XLEN-1:0]    clamp_res
);
  localparam int POS_W = $clog2(XLEN);

  logic [POS_W-1:0] pos;
  logic [XLEN-1:0]  hi_mask;
  logic [XLEN-1:0]  lo_mask;
  logic [XLEN-1:0]  sign_fill;
  logic             fits;

  assign pos = POS_W'(t_fld) + POS_W'(BASE);

  genvar i;
  generate
    for (i = 0; i < XLEN; i++) begin : g_bit
      assign hi_mask[i]  = (pos < POS_W'(i));
      assign lo_mask[i]  = (POS_W'(i) < pos);
      assign sext_res[i] = hi_mask[i] ? s_val[pos] : s_val[i];
    end
  endgenerate

  assign sign_fill = {XLEN{s_val[XLEN-1]}};
  assign fits      = (((s_val ^ sign_fill) & ~lo_mask) == '0);

  always_comb begin
    if (fits)
      clamp_res = s_val;
    else if (s_val[XLEN-1])
      clamp_res = ~lo_mask;
    else
      clamp_res = lo_mask;
  end

  always_comb begin
    a_r4_clamp_range: assert (($signed(clamp_res) <= $signed(lo_mask)) &&
                              ($signed(clamp_res) >= $signed(~lo_mask)));
    a_r3_sext_low_kept: assert (((sext_res ^ s_val) & lo_mask) == '0);
  end
endmodule

// File: rtl/mx_minmax.sv
module mx_minmax #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic            pick_max,
  input  logic            unsig,
  output logic [XLEN-1:0] res
);
  logic s_le, s_ge, u_le, u_ge, take_a;

  assign s_le = ($signed(a) <= $signed(b));
  assign s_ge = ($signed(a) >= $signed(b));
  assign u_le = (a <= b);
  assign u_ge = (a >= b);

  always_comb begin
    case ({unsig, pick_max})
      2'b00:   take_a = s_le;
      2'b01:   take_a = s_ge;
      2'b10:   take_a = u_le;
      default: take_a = u_ge;
    endcase
  end

  assign res = take_a ? a : b;

  always_comb begin
    a_r5_pick_operand: assert ((res == a) || (res == b));
    if (!pick_max && unsig)
      a_r5_umin_bound: assert ((res <= a) && (res <= b));
    if (pick_max && !unsig)
      a_r5_smax_bound: assert (($signed(res) >= $signed(a)) && ($signed(res) >= $signed(b)));
  end
endmodule

// File: rtl/mx_condmv.sv
module mx_condmv #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] t_val,
  input  logic [1:0]      kind,
  output logic            take
);
  logic is_zero, is_neg;

  assign is_zero = (t_val == '0);
  assign is_neg  = t_val[XLEN-1];

  always_comb begin
    case (kind)
      2'd0:    take = is_zero;
      2'd1:    take = !is_zero;
      2'd2:    take = is_neg;
      default: take = !is_neg;
    endcase
  end

  always_comb begin
    if (kind == 2'd2 && take)
      a_r6_neg_test: assert (t_val[XLEN-1]);
    if (kind == 2'd0 && take)
      a_r6_zero_test: assert (t_val == '0);
  end
endmodule

// File: rtl/misc_exec_unit.sv
module misc_exec_unit #(
  parameter int XLEN     = 32,
  parameter int FIELD_W  = 4,
  parameter int POS_BASE = 7,
  parameter bit HAS_MISC = 1'b1,
  parameter bit HAS_BOOL = 1'b0
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  input  logic [mx_pkg::SEL_W-1:0]   op_sel,
  input  logic [FIELD_W-1:0]         r_fld,
  input  logic [FIELD_W-1:0]         t_fld,
  input  logic [XLEN-1:0]            s_val,
  input  logic [XLEN-1:0]            t_val,
  input  logic [XLEN-1:0]            r_val,
  output logic                       out_valid,
  output logic                       wb_en,
  output logic [FIELD_W-1:0]         wb_idx,
  output logic [XLEN-1:0]            wb_data,
  output logic                       illegal
);
  import mx_pkg::*;

  op_e             op;
  logic [XLEN-1:0] sext_res, clamp_res, mm_res;
  logic            mv_take;
  ctl_t            ctl;
  logic [XLEN-1:0] nxt_data;

  assign op = op_e'(op_sel);

  mx_bitpos #(.XLEN(XLEN), .FIELD_W(FIELD_W), .BASE(POS_BASE)) u_bitpos (
    .s_val     (s_val),
    .t_fld     (t_fld),
    .sext_res  (sext_res),
    .clamp_res (clamp_res)
  );

  mx_minmax #(.XLEN(XLEN)) u_minmax (
    .a        (s_val),
    .b        (t_val),
    .pick_max (op_sel[0]),
    .unsig    (op_sel[1]),
    .res      (mm_res)
  );

  mx_condmv #(.XLEN(XLEN)) u_condmv (
    .t_val (t_val),
    .kind  (op_sel[1:0]),
    .take  (mv_take)
  );

  always_comb begin
    ctl = '{ill: 1'b0, wr: 1'b0};
    nxt_data = r_val;
    case (op)
      OP_SEXT, OP_CLAMP, OP_MIN, OP_MAX, OP_MINU, OP_MAXU: begin
        if (HAS_MISC) begin
          ctl.wr = 1'b1;
          case (op)
            OP_SEXT:  nxt_data = sext_res;
            OP_CLAMP: nxt_data = clamp_res;
            default:  nxt_data = mm_res;
          endcase
        end else begin
          ctl.ill = 1'b1;
        end
      end
      OP_MV_EQZ, OP_MV_NEZ, OP_MV_LTZ, OP_MV_GEZ: begin
        if (mv_take) begin
          ctl.wr   = 1'b1;
          nxt_data = s_val;
        end
      end
      OP_BMV_F, OP_BMV_T: begin
        ctl.ill = !HAS_BOOL;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      wb_en     <= 1'b0;
      illegal   <= 1'b0;
      wb_idx    <= '0;
      wb_data   <= '0;
    end else begin
      out_valid <= in_valid;
      wb_en     <= in_valid && ctl.wr && !ctl.ill;
      illegal   <= in_valid && ctl.ill;
      if (in_valid) begin
        wb_idx  <= r_fld;
        wb_data <= nxt_data;
      end
    end
  end

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r2_idle_follows: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  a_r2_idx_capture: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (wb_idx == $past(r_fld)));
  a_r1_quiet_outputs: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (!wb_en && !illegal));
  a_r11_ill_blocks_write: assert property (@(posedge clk) disable iff (rst)
    illegal |-> !wb_en);
  a_r7_hold_old_r: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !wb_en) |-> (wb_data == $past(r_val)));
  a_r6_move_source: assert property (@(posedge clk) disable iff (rst)
    (out_valid && wb_en && ($past(op_sel[3:2]) == 2'b10)) |-> (wb_data == $past(s_val)));
  a_r10_sys_quiet: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (op_sel == 4'd0 || op_sel == 4'd1 || op_sel == 4'd14 || op_sel == 4'd15))
    |=> (!wb_en && !illegal));
endmodule

// File: tb/misc_exec_unit_tb.sv
module misc_exec_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [3:0]  op_sel = '0, r_fld = '0, t_fld = '0;
  logic [31:0] s_val = '0, t_val = '0, r_val = '0;

  logic        ov_a, en_a, ill_a, ov_b, en_b, ill_b;
  logic [3:0]  idx_a, idx_b;
  logic [31:0] d_a, d_b;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  misc_exec_unit #(.HAS_MISC(1'b1), .HAS_BOOL(1'b0)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel), .r_fld(r_fld),
    .t_fld(t_fld), .s_val(s_val), .t_val(t_val), .r_val(r_val),
    .out_valid(ov_a), .wb_en(en_a), .wb_idx(idx_a), .wb_data(d_a), .illegal(ill_a));

  misc_exec_unit #(.HAS_MISC(1'b0), .HAS_BOOL(1'b1)) u_dut_lite (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel), .r_fld(r_fld),
    .t_fld(t_fld), .s_val(s_val), .t_val(t_val), .r_val(r_val),
    .out_valid(ov_b), .wb_en(en_b), .wb_idx(idx_b), .wb_data(d_b), .illegal(ill_b));

  function automatic logic [31:0] pat(input int k);
    case (k)
      0: pat = 32'h0000_0000;
      1: pat = 32'hFFFF_FFFF;
      2: pat = 32'h7FFF_FFFF;
      3: pat = 32'h8000_0000;
      4: pat = 32'h0000_007F;
      5: pat = 32'h0000_0080;
      6: pat = 32'hFFFF_8000;
      7: pat = 32'h0000_7FFF;
      8: pat = 32'hFFFF_FF80;
      9: pat = 32'h0040_0000;
      10: pat = 32'hFFC0_0000;
      default: pat = 32'(k) * 32'h9E37_79B9;
    endcase
  endfunction

  // returns {illegal, write, data}
  function automatic logic [33:0] model(input bit misc, input bit boolopt,
      input int sel, input int tf, input logic [31:0] s, input logic [31:0] t,
      input logic [31:0] r);
    logic ill, wr;
    logic [31:0] d;
    logic signed [31:0] x;
    longint lo, hi, sv;
    int p, sh;
    ill = 1'b0; wr = 1'b0; d = r;
    p = tf + 7;
    case (sel)
      2, 3, 4, 5, 6, 7: begin
        if (!misc) ill = 1'b1;
        else begin
          wr = 1'b1;
          case (sel)
            2: begin sh = 31 - p; x = $signed(s << sh); d = 32'(x >>> sh); end
            3: begin
              lo = -(longint'(1) << p); hi = (longint'(1) << p) - 1;
              sv = longint'($signed(s));
              if (sv < lo) d = 32'(lo);
              else if (sv > hi) d = 32'(hi);
              else d = s;
            end
            4: d = ($signed(s) <= $signed(t)) ? s : t;
            5: d = ($signed(s) >= $signed(t)) ? s : t;
            6: d = (s <= t) ? s : t;
            default: d = (s >= t) ? s : t;
          endcase
        end
      end
      8:  if (t == 0) begin wr = 1'b1; d = s; end
      9:  if (t != 0) begin wr = 1'b1; d = s; end
      10: if ($signed(t) < 0) begin wr = 1'b1; d = s; end
      11: if ($signed(t) >= 0) begin wr = 1'b1; d = s; end
      12, 13: ill = !boolopt;
      default: ;
    endcase
    model = {ill, wr, d};
  endfunction

  function automatic string tag(input bit misc, input int sel, input bit wr);
    if (!misc && sel >= 2 && sel <= 7) return "R8/R11";
    case (sel)
      2: return "R3";
      3: return "R4";
      4, 5, 6, 7: return "R5";
      8, 9, 10, 11: return wr ? "R6" : "R6/R7";
      12, 13: return "R9/R11";
      default: return "R10/R7";
    endcase
  endfunction

  task automatic check(input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic run_vec(input int sel, input int tf, input int k);
    logic [31:0] s, t, r;
    logic [33:0] ea, eb;
    s = pat(k);
    t = (k % 4 == 0) ? s : pat((k + 5) % 14);
    r = ~pat(k) ^ 32'h5A5A_0000;
    @(negedge clk);
    in_valid = 1'b1; op_sel = 4'(sel); t_fld = 4'(tf); r_fld = 4'(tf) ^ 4'h9;
    s_val = s; t_val = t; r_val = r;
    @(negedge clk);
    in_valid = 1'b0;
    ea = model(1'b1, 1'b0, sel, tf, s, t, r);
    eb = model(1'b0, 1'b1, sel, tf, s, t, r);
    check("R2", "valid/idx full", {59'd0, ov_a, idx_a}, {59'd0, 1'b1, 4'(tf) ^ 4'h9});
    check(tag(1'b1, sel, ea[32]), "full {ill,en,data}", {30'd0, ill_a, en_a, d_a}, {30'd0, ea});
    check(tag(1'b0, sel, eb[32]), "lite {ill,en,data}", {30'd0, ill_b, en_b, d_b}, {30'd0, eb});
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state, no strobe yet
    check("R1", "reset outputs", {61'd0, ov_a, en_a, ill_a}, 64'd0);
    check("R1", "reset outputs lite", {61'd0, ov_b, en_b, ill_b}, 64'd0);

    for (int sel = 0; sel < 16; sel++)
      for (int tf = 0; tf < 16; tf++)
        for (int k = 0; k < 14; k++)
          run_vec(sel, tf, k);

    // R2: an idle cycle gives no result
    @(negedge clk);
    check("R2", "idle valid", {62'd0, ov_a, ov_b}, 64'd0);
    check("R2", "idle write", {62'd0, en_a, en_b}, 64'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule